// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Unit

This block lives in the decode stage of a statically scheduled pipeline that issues two instructions per cycle. Every cycle it receives one 64-bit packet from the fetch/decode register. The packet carries an arithmetic/branch instruction in one half and a memory-access instruction in the other. The unit splits the packet and decodes which registers each slot reads and writes. It then decides whether the packet may enter the execute stage.

Two hazards are handled. A load in the execute stage cannot yet supply its data. If either instruction of the packet now in decode reads that register, the whole packet waits one cycle. During that cycle the packet fetch address and the fetch/decode register are held and an all-nop pair enters execute. A packet whose memory slot reads or writes the register that its own arithmetic slot writes cannot be served by forwarding, so it is flagged as wrongly scheduled. For the two instructions in execute, the unit also chooses, for each of the four source operands, whether the value comes from the register file or from one of the later pipeline stages.

Top module: `dual_issue_hazard_unit`

## Requirements
- R1: Packet bits 63:32 are the memory slot and bits 31:0 are the arithmetic slot. In a cycle without a stall, the next clock edge loads the arithmetic slot into `ex_alu_instr_o` and the memory slot into `ex_ls_instr_o`.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16] and rd [15:11], and an all-zero word is a nop. In the arithmetic slot, opcode 0x00 reads rs and rt and writes rd, 0x08 reads rs and writes rt, and 0x04 reads rs and rt and writes nothing. In the memory slot, 0x23 (load) reads rs and writes rt, and 0x2B (store) reads rs and rt and writes nothing. Every other opcode, and every nop, reads and writes no register.
- R3: Register 0 never causes a stall, never causes a scheduling flag and is never forwarded.
- R4: `stall_o` is high in the same cycle in which the memory slot in execute is a load to register d≠0 and any source of either slot of `pkt_i` equals d. A stall lasts exactly one cycle for any one packet.
- R5: In a stall cycle, `pc_o` holds its value and the next edge loads zero into both execute slots. The held packet then moves on in the following cycle.
- R6: Reset sets `pc_o` to `RESET_PC`. Each cycle without a stall advances `pc_o` by 8 at the clock edge.
- R7: `sched_err_o` is high, in the same cycle, when the arithmetic slot of `pkt_i` writes register d≠0 and the memory slot reads d or also writes d. It causes no stall.
- R8: Each of `fwd_alu_a_o`, `fwd_alu_b_o`, `fwd_ls_a_o` and `fwd_ls_b_o` selects the source of the rs or rt operand of the matching execute slot. The codes are 0 for the register file, 1 for the arithmetic result one stage ahead, 2 for the arithmetic result two stages ahead and 3 for the load result two stages ahead. A match one stage ahead wins over a match two stages ahead.
- R9: When both results two stages ahead write the operand's register, the load result (code 3) is chosen.
- R10: While reset is held, `pc_o` equals `RESET_PC`, both execute slots are zero and every forwarding select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pkt_i | input | 64 | Packet in the decode stage |
| pc_o | output | PC_W | Packet fetch address |
| stall_o | output | 1 | Hold fetch address and decode register, insert a nop pair |
| sched_err_o | output | 1 | Packet has an illegal same-packet register dependence |
| ex_alu_instr_o | output | 32 | Arithmetic-slot instruction in execute |
| ex_ls_instr_o | output | 32 | Memory-slot instruction in execute |
| fwd_alu_a_o | output | 2 | Operand select, arithmetic slot rs |
| fwd_alu_b_o | output | 2 | Operand select, arithmetic slot rt |
| fwd_ls_a_o | output | 2 | Operand select, memory slot base (rs) |
| fwd_ls_b_o | output | 2 | Operand select, memory slot store data (rt) |

## Verification
The bound checker watches, on every cycle, how the unit responds to a stall: the fetch address holds, a nop pair follows, and no two stalls come back to back. It also checks that unstalled packets pass through in split order with the address stepping by 8, and that a nop in execute never asks for forwarding. Only the bench's scenarios can show whether the right register matches were found. These scenarios cover which decoded operand triggers a stall, the scheduling flag for read and write conflicts inside a packet, register 0 being exempt, and which stage and slot a forwarding select picks when results collide.

// File: rtl/dih_pkg.sv
package dih_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned PKT_W   = 2 * INSTR_W;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned N_OPND  = 4;

  // field positions of one slot word
  localparam int unsigned OPC_HI = 31;
  localparam int unsigned OPC_LO = 26;
  localparam int unsigned RS_HI  = 25;
  localparam int unsigned RS_LO  = 21;
  localparam int unsigned RT_HI  = 20;
  localparam int unsigned RT_LO  = 16;
  localparam int unsigned RD_HI  = 15;
  localparam int unsigned RD_LO  = 11;

  localparam logic [5:0] OPC_RR  = 6'h00;
  localparam logic [5:0] OPC_BR  = 6'h04;
  localparam logic [5:0] OPC_IMM = 6'h08;
  localparam logic [5:0] OPC_LD  = 6'h23;
  localparam logic [5:0] OPC_ST  = 6'h2B;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef struct packed {
    logic     vld;
    reg_idx_t idx;
  } dst_t;

  typedef struct packed {
    logic     a_vld;
    reg_idx_t a;
    logic     b_vld;
    reg_idx_t b;
    logic     d_vld;
    reg_idx_t d;
  } slot_regs_t;

  typedef enum logic [1:0] {
    FWD_RF     = 2'd0,
    FWD_EM_ALU = 2'd1,
    FWD_WB_ALU = 2'd2,
    FWD_WB_LSU = 2'd3
  } fwd_sel_t;

  function automatic logic slot_reads(slot_regs_t s, reg_idx_t r);
    return (s.a_vld && (s.a == r)) || (s.b_vld && (s.b == r));
  endfunction

endpackage

// File: rtl/dih_slot_decode.sv
module dih_slot_decode
  import dih_pkg::*;
#(
  parameter bit LS_SLOT = 1'b0
) (
  input  logic [INSTR_W-1:0] instr_i,
  output slot_regs_t         regs_o
);

  slot_regs_t raw;
  logic       is_nop;

  assign is_nop = (instr_i == '0);

  generate
    if (LS_SLOT) begin : g_ls
      always_comb begin
        raw = '0;
        if (!is_nop) begin
          unique case (instr_i[OPC_HI:OPC_LO])
            OPC_LD: begin
              raw.a_vld = 1'b1;
              raw.a     = instr_i[RS_HI:RS_LO];
              raw.d_vld = 1'b1;
              raw.d     = instr_i[RT_HI:RT_LO];
            end
            OPC_ST: begin
              raw.a_vld = 1'b1;
              raw.a     = instr_i[RS_HI:RS_LO];
              raw.b_vld = 1'b1;
              raw.b     = instr_i[RT_HI:RT_LO];
            end
            default: raw = '0;
          endcase
        end
      end
    end else begin : g_alu
      always_comb begin
        raw = '0;
        if (!is_nop) begin
          unique case (instr_i[OPC_HI:OPC_LO])
            OPC_RR: begin
              raw.a_vld = 1'b1;
              raw.a     = instr_i[RS_HI:RS_LO];
              raw.b_vld = 1'b1;
              raw.b     = instr_i[RT_HI:RT_LO];
              raw.d_vld = 1'b1;
              raw.d     = instr_i[RD_HI:RD_LO];
            end
            OPC_IMM: begin
              raw.a_vld = 1'b1;
              raw.a     = instr_i[RS_HI:RS_LO];
              raw.d_vld = 1'b1;
              raw.d     = instr_i[RT_HI:RT_LO];
            end
            OPC_BR: begin
              raw.a_vld = 1'b1;
              raw.a     = instr_i[RS_HI:RS_LO];
              raw.b_vld = 1'b1;
              raw.b     = instr_i[RT_HI:RT_LO];
            end
            default: raw = '0;
          endcase
        end
      end
    end
  endgenerate

  // register 0 is hard-wired: it is neither a producer nor a consumer
  always_comb begin
    regs_o       = raw;
    regs_o.a_vld = raw.a_vld && (raw.a != '0);
    regs_o.b_vld = raw.b_vld && (raw.b != '0);
    regs_o.d_vld = raw.d_vld && (raw.d != '0);
  end

endmodule

// File: rtl/dih_hazard_check.sv
module dih_hazard_check
  import dih_pkg::*;
(
  input  slot_regs_t id_alu_i,
  input  slot_regs_t id_ls_i,
  input  dst_t       ex_load_i,
  output logic       load_use_o,
  output logic       sched_err_o
);

  logic use_by_alu;
  logic use_by_ls;
  logic raw_in_pkt;
  logic waw_in_pkt;

  always_comb begin
    use_by_alu  = slot_reads(id_alu_i, ex_load_i.idx);
    use_by_ls   = slot_reads(id_ls_i, ex_load_i.idx);
    load_use_o  = ex_load_i.vld && (use_by_alu || use_by_ls);

    raw_in_pkt  = slot_reads(id_ls_i, id_alu_i.d);
    waw_in_pkt  = id_ls_i.d_vld && (id_ls_i.d == id_alu_i.d);
    sched_err_o = id_alu_i.d_vld && (raw_in_pkt || waw_in_pkt);
  end

endmodule

// File: rtl/dih_fwd_select.sv
module dih_fwd_select
  import dih_pkg::*;
(
  input  logic     src_vld_i,
  input  reg_idx_t src_idx_i,
  input  dst_t     em_alu_i,
  input  dst_t     wb_alu_i,
  input  dst_t     wb_ls_i,
  output fwd_sel_t sel_o
);

  logic hit_em_alu;
  logic hit_wb_alu;
  logic hit_wb_ls;

  always_comb begin
    hit_em_alu = src_vld_i && em_alu_i.vld && (em_alu_i.idx == src_idx_i);
    hit_wb_ls  = src_vld_i && wb_ls_i.vld  && (wb_ls_i.idx  == src_idx_i);
    hit_wb_alu = src_vld_i && wb_alu_i.vld && (wb_alu_i.idx == src_idx_i);
    if (hit_em_alu)      sel_o = FWD_EM_ALU;
    else if (hit_wb_ls)  sel_o = FWD_WB_LSU;
    else if (hit_wb_alu) sel_o = FWD_WB_ALU;
    else                 sel_o = FWD_RF;
  end

endmodule

// File: rtl/dual_issue_hazard_unit.sv
module dual_issue_hazard_unit
  import dih_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PKT_W-1:0]   pkt_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               stall_o,
  output logic               sched_err_o,
  output logic [INSTR_W-1:0] ex_alu_instr_o,
  output logic [INSTR_W-1:0] ex_ls_instr_o,
  output logic [1:0]         fwd_alu_a_o,
  output logic [1:0]         fwd_alu_b_o,
  output logic [1:0]         fwd_ls_a_o,
  output logic [1:0]         fwd_ls_b_o
);

  localparam int unsigned PKT_BYTES = PKT_W / 8;
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(PKT_BYTES);

  // decode stage
  logic [INSTR_W-1:0] id_alu_w;
  logic [INSTR_W-1:0] id_ls_w;
  slot_regs_t         id_alu_r;
  slot_regs_t         id_ls_r;

  // pipeline state
  logic [PC_W-1:0]    pc_q,  pc_d;
  logic               pc_en;
  logic [INSTR_W-1:0] ex_alu_q, ex_alu_d;
  logic [INSTR_W-1:0] ex_ls_q,  ex_ls_d;
  dst_t               em_alu_q, em_alu_d;
  dst_t               em_ls_q,  em_ls_d;
  dst_t               wb_alu_q, wb_alu_d;
  dst_t               wb_ls_q,  wb_ls_d;

  slot_regs_t         ex_alu_r;
  slot_regs_t         ex_ls_r;
  dst_t               ex_load;
  logic               load_use;
  logic               sched_err;

  assign id_alu_w = pkt_i[INSTR_W-1:0];
  assign id_ls_w  = pkt_i[PKT_W-1:INSTR_W];

  dih_slot_decode #(.LS_SLOT(1'b0)) u_dec_id_alu (.instr_i(id_alu_w), .regs_o(id_alu_r));
  dih_slot_decode #(.LS_SLOT(1'b1)) u_dec_id_ls  (.instr_i(id_ls_w),  .regs_o(id_ls_r));
  dih_slot_decode #(.LS_SLOT(1'b0)) u_dec_ex_alu (.instr_i(ex_alu_q), .regs_o(ex_alu_r));
  dih_slot_decode #(.LS_SLOT(1'b1)) u_dec_ex_ls  (.instr_i(ex_ls_q),  .regs_o(ex_ls_r));

  // memory slot writes a register only for a load
  assign ex_load = '{vld: ex_ls_r.d_vld, idx: ex_ls_r.d};

  dih_hazard_check u_hazard (
    .id_alu_i    (id_alu_r),
    .id_ls_i     (id_ls_r),
    .ex_load_i   (ex_load),
    .load_use_o  (load_use),
    .sched_err_o (sched_err)
  );

  // next state
  always_comb begin
    pc_en    = ~load_use;
    pc_d     = pc_q + PC_STEP;
    ex_alu_d = load_use ? '0 : id_alu_w;
    ex_ls_d  = load_use ? '0 : id_ls_w;
    em_alu_d = '{vld: ex_alu_r.d_vld, idx: ex_alu_r.d};
    em_ls_d  = ex_load;
    wb_alu_d = em_alu_q;
    wb_ls_d  = em_ls_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ex_alu_q <= '0;
      ex_ls_q  <= '0;
      em_alu_q <= '0;
      em_ls_q  <= '0;
      wb_alu_q <= '0;
      wb_ls_q  <= '0;
    end else begin
      if (pc_en) begin
        pc_q <= pc_d;
      end
      ex_alu_q <= ex_alu_d;
      ex_ls_q  <= ex_ls_d;
      em_alu_q <= em_alu_d;
      em_ls_q  <= em_ls_d;
      wb_alu_q <= wb_alu_d;
      wb_ls_q  <= wb_ls_d;
    end
  end

  // forwarding selects for the four execute-stage operands
  logic     [N_OPND-1:0] opnd_vld;
  reg_idx_t              opnd_idx [N_OPND];
  fwd_sel_t              opnd_sel [N_OPND];

  assign opnd_vld    = {ex_ls_r.b_vld, ex_ls_r.a_vld, ex_alu_r.b_vld, ex_alu_r.a_vld};
  assign opnd_idx[0] = ex_alu_r.a;
  assign opnd_idx[1] = ex_alu_r.b;
  assign opnd_idx[2] = ex_ls_r.a;
  assign opnd_idx[3] = ex_ls_r.b;

  generate
    for (genvar g = 0; g < N_OPND; g++) begin : g_fwd
      dih_fwd_select u_fwd (
        .src_vld_i (opnd_vld[g]),
        .src_idx_i (opnd_idx[g]),
        .em_alu_i  (em_alu_q),
        .wb_alu_i  (wb_alu_q),
        .wb_ls_i   (wb_ls_q),
        .sel_o     (opnd_sel[g])
      );
    end
  endgenerate

  assign pc_o           = pc_q;
  assign stall_o        = load_use;
  assign sched_err_o    = sched_err;
  assign ex_alu_instr_o = ex_alu_q;
  assign ex_ls_instr_o  = ex_ls_q;
  assign fwd_alu_a_o    = opnd_sel[0];
  assign fwd_alu_b_o    = opnd_sel[1];
  assign fwd_ls_a_o     = opnd_sel[2];
  assign fwd_ls_b_o     = opnd_sel[3];

endmodule

// File: rtl/dih_checker.sv
module dih_checker
  import dih_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PKT_W-1:0]   pkt_i,
  input logic [PC_W-1:0]    pc_i,
  input logic               stall_i,
  input logic [INSTR_W-1:0] ex_alu_i,
  input logic [INSTR_W-1:0] ex_ls_i,
  input logic [1:0]         fwd_alu_a_i,
  input logic [1:0]         fwd_alu_b_i,
  input logic [1:0]         fwd_ls_a_i,
  input logic [1:0]         fwd_ls_b_i
);

  localparam logic [PC_W-1:0] STEP = PC_W'(PKT_W / 8);

  p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> (ex_alu_i == '0) && (ex_ls_i == '0));

  p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_i));

  p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |=> (pc_i == $past(pc_i) + STEP));

  p_slot_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |=> (ex_alu_i == $past(pkt_i[INSTR_W-1:0])) &&
                 (ex_ls_i  == $past(pkt_i[PKT_W-1:INSTR_W])));

  p_single_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> !stall_i);

  p_nop_alu_no_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_alu_i == '0) |-> (fwd_alu_a_i == 2'd0) && (fwd_alu_b_i == 2'd0));

  p_nop_ls_no_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ls_i == '0) |-> (fwd_ls_a_i == 2'd0) && (fwd_ls_b_i == 2'd0));

endmodule

bind dual_issue_hazard_unit dih_checker #(.PC_W(PC_W)) u_dih_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_i       (pkt_i),
  .pc_i        (pc_o),
  .stall_i     (stall_o),
  .ex_alu_i    (ex_alu_instr_o),
  .ex_ls_i     (ex_ls_instr_o),
  .fwd_alu_a_i (fwd_alu_a_o),
  .fwd_alu_b_i (fwd_alu_b_o),
  .fwd_ls_a_i  (fwd_ls_a_o),
  .fwd_ls_b_i  (fwd_ls_b_o)
);

// File: tb/test_dual_issue_hazard_unit.sv
module test_dual_issue_hazard_unit;

  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] pkt;
  logic [31:0] pc;
  logic        stall, serr;
  logic [31:0] ex_alu, ex_ls;
  logic [1:0]  f_aa, f_ab, f_la, f_lb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5ns clk = ~clk;

  dual_issue_hazard_unit #(.PC_W(32), .RESET_PC(RST_PC)) i_dual_issue_hazard_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .pkt_i          (pkt),
    .pc_o           (pc),
    .stall_o        (stall),
    .sched_err_o    (serr),
    .ex_alu_instr_o (ex_alu),
    .ex_ls_instr_o  (ex_ls),
    .fwd_alu_a_o    (f_aa),
    .fwd_alu_b_o    (f_ab),
    .fwd_ls_a_o     (f_la),
    .fwd_ls_b_o     (f_lb)
  );

  // ---------------- instruction builders ----------------
  function automatic logic [31:0] i_rr(input logic [4:0] rd, rs, rt);
    return {6'h00, rs, rt, rd, 5'd0, 6'h21};
  endfunction
  function automatic logic [31:0] i_imm(input logic [4:0] rt, rs);
    return {6'h08, rs, rt, 16'h0004};
  endfunction
  function automatic logic [31:0] i_br(input logic [4:0] rs, rt);
    return {6'h04, rs, rt, 16'h0010};
  endfunction
  function automatic logic [31:0] i_ld(input logic [4:0] rt, base);
    return {6'h23, base, rt, 16'h0008};
  endfunction
  function automatic logic [31:0] i_st(input logic [4:0] rt, base);
    return {6'h2B, base, rt, 16'h000C};
  endfunction
  function automatic logic [31:0] i_unk(input logic [4:0] rs, rt);
    return {6'h3F, rs, rt, 16'h0000};
  endfunction
  localparam logic [31:0] NOP = 32'h0;

  // ---------------- reference model from the requirements ----------------
  // returns {valid, index} of source 'second' (0 = rs, 1 = rt) read by word w
  function automatic logic [5:0] b_src(input logic [31:0] w, input bit ls, input bit second);
    logic [5:0] op;
    logic [5:0] r;
    op = w[31:26];
    r  = 6'd0;
    if (w != 32'h0) begin
      if (!ls) begin
        if (op == 6'h00 || op == 6'h04) r = second ? {1'b1, w[20:16]} : {1'b1, w[25:21]};
        else if (op == 6'h08 && !second) r = {1'b1, w[25:21]};
      end else begin
        if (op == 6'h2B) r = second ? {1'b1, w[20:16]} : {1'b1, w[25:21]};
        else if (op == 6'h23 && !second) r = {1'b1, w[25:21]};
      end
    end
    if (r[4:0] == 5'd0) r = 6'd0;
    return r;
  endfunction

  function automatic logic [5:0] b_dst(input logic [31:0] w, input bit ls);
    logic [5:0] op;
    logic [5:0] r;
    op = w[31:26];
    r  = 6'd0;
    if (w != 32'h0) begin
      if (!ls && op == 6'h00) r = {1'b1, w[15:11]};
      else if (!ls && op == 6'h08) r = {1'b1, w[20:16]};
      else if (ls && op == 6'h23) r = {1'b1, w[20:16]};
    end
    if (r[4:0] == 5'd0) r = 6'd0;
    return r;
  endfunction

  function automatic logic [1:0] b_fwd(input logic [5:0] s, input logic [31:0] em_a,
                                       input logic [31:0] wb_a, input logic [31:0] wb_l);
    logic [5:0] e, wa, wl;
    e  = b_dst(em_a, 1'b0);
    wa = b_dst(wb_a, 1'b0);
    wl = b_dst(wb_l, 1'b1);
    if (!s[5])                       return 2'd0;
    if (e[5]  && e[4:0]  == s[4:0])  return 2'd1;
    if (wl[5] && wl[4:0] == s[4:0])  return 2'd3;
    if (wa[5] && wa[4:0] == s[4:0])  return 2'd2;
    return 2'd0;
  endfunction

  logic [31:0] m_pc;
  logic [31:0] m_ex_a, m_ex_l, m_em_a, m_em_l, m_wb_a, m_wb_l;

  typedef struct {
    logic [31:0] pc;
    logic        stall;
    logic        serr;
    logic [31:0] ex_a;
    logic [31:0] ex_l;
    logic [7:0]  fw;
    string       note;
  } item_t;

  item_t sb_q[$];

  task automatic m_reset();
    m_pc = RST_PC;
    m_ex_a = '0; m_ex_l = '0; m_em_a = '0; m_em_l = '0; m_wb_a = '0; m_wb_l = '0;
  endtask

  function automatic item_t m_expect(input logic [63:0] p, input string note);
    item_t it;
    logic [5:0] ld, ad;
    logic [5:0] s0, s1, s2, s3;
    ld = b_dst(m_ex_l, 1'b1);
    s0 = b_src(p[31:0], 1'b0, 1'b0);
    s1 = b_src(p[31:0], 1'b0, 1'b1);
    s2 = b_src(p[63:32], 1'b1, 1'b0);
    s3 = b_src(p[63:32], 1'b1, 1'b1);
    it.stall = ld[5] && ((s0 == ld) || (s1 == ld) || (s2 == ld) || (s3 == ld));
    ad = b_dst(p[31:0], 1'b0);
    it.serr = ad[5] && ((s2 == ad) || (s3 == ad) || (b_dst(p[63:32], 1'b1) == ad));
    it.pc   = m_pc;
    it.ex_a = m_ex_a;
    it.ex_l = m_ex_l;
    it.fw   = {b_fwd(b_src(m_ex_l, 1'b1, 1'b1), m_em_a, m_wb_a, m_wb_l),
               b_fwd(b_src(m_ex_l, 1'b1, 1'b0), m_em_a, m_wb_a, m_wb_l),
               b_fwd(b_src(m_ex_a, 1'b0, 1'b1), m_em_a, m_wb_a, m_wb_l),
               b_fwd(b_src(m_ex_a, 1'b0, 1'b0), m_em_a, m_wb_a, m_wb_l)};
    it.note = note;
    return it;
  endfunction

  task automatic m_step(input logic [63:0] p, input logic stl);
    m_wb_a = m_em_a; m_wb_l = m_em_l;
    m_em_a = m_ex_a; m_em_l = m_ex_l;
    m_ex_a = stl ? 32'h0 : p[31:0];
    m_ex_l = stl ? 32'h0 : p[63:32];
    if (!stl) m_pc = m_pc + 32'd8;
  endtask

  // ---------------- driver ----------------
  task automatic drive(input logic [63:0] p, input string note, output logic stl);
    item_t it;
    @(negedge clk);
    pkt = p;
    it  = m_expect(p, note);
    sb_q.push_back(it);
    stl = it.stall;
    m_step(p, it.stall);
  endtask

  // a stalled packet stays in the decode register, so it is presented again
  task automatic send(input logic [31:0] ls_w, input logic [31:0] alu_w, input string note);
    logic stl;
    drive({ls_w, alu_w}, note, stl);
    while (stl) drive({ls_w, alu_w}, {note, " (held)"}, stl);
  endtask

  // ---------------- monitor ----------------
  task automatic chk(input bit ok, input string req, input string note,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, note, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1ns;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk(pc === it.pc,       "R6 pc",          it.note, 64'(pc),     64'(it.pc));
        chk(stall === it.stall, "R4 stall",       it.note, 64'(stall),  64'(it.stall));
        chk(serr === it.serr,   "R7 sched_err",   it.note, 64'(serr),   64'(it.serr));
        chk(ex_alu === it.ex_a, "R1 ex_alu",      it.note, 64'(ex_alu), 64'(it.ex_a));
        chk(ex_ls === it.ex_l,  "R1 ex_ls",       it.note, 64'(ex_ls),  64'(it.ex_l));
        chk({f_lb, f_la, f_ab, f_aa} === it.fw, "R8 forwarding", it.note,
            64'({f_lb, f_la, f_ab, f_aa}), 64'(it.fw));
      end
    end
  end

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_sim();
  end

  // ---------------- scenarios ----------------
  initial begin
    item_t it;
    rst_n = 1'b0;
    pkt   = '0;
    m_reset();
    // R10: reset state with a hazardous-looking packet on the input
    repeat (2) @(negedge clk);
    pkt = {i_st(5'd3, 5'd4), i_rr(5'd3, 5'd1, 5'd2)};
    it  = m_expect(64'h0, "R10 reset state");
    it.serr = 1'b1;
    sb_q.push_back(it);
    @(negedge clk);
    pkt   = '0;
    rst_n = 1'b1;
    m_step(64'h0, 1'b0);

    // R2/R8: arithmetic chain forwarded from one and two stages ahead
    send(NOP, i_rr(5'd3, 5'd1, 5'd2), "R2 rr writes rd");
    send(NOP, i_rr(5'd4, 5'd3, 5'd3), "R8 em forward both operands");
    send(i_st(5'd3, 5'd4), NOP, "R8 store base from em, data from wb");
    send(NOP, NOP, "R8 drain");

    // R4/R5: load-use from the arithmetic slot, then R9-style load forward
    send(i_ld(5'd5, 5'd1), NOP, "R4 load r5");
    send(NOP, i_rr(5'd6, 5'd5, 5'd1), "R5 stall on arithmetic use");
    send(NOP, NOP, "R8 load result from wb");

    // R4: load-use through the memory slot (store data and base)
    send(i_ld(5'd7, 5'd2), NOP, "R4 load r7");
    send(i_st(5'd7, 5'd8), NOP, "R4 stall on store data");
    send(i_ld(5'd8, 5'd2), NOP, "R4 load r8");
    send(i_ld(5'd9, 5'd8), i_imm(5'd10, 5'd1), "R5 stall on base, both slots held");
    send(NOP, NOP, "R5 drain");

    // R3: register 0 never stalls nor forwards
    send(i_ld(5'd0, 5'd1), NOP, "R3 load to r0");
    send(NOP, i_rr(5'd11, 5'd0, 5'd0), "R3 no stall on r0");
    send(NOP, i_rr(5'd0, 5'd1, 5'd2), "R3 write r0");
    send(NOP, i_rr(5'd12, 5'd0, 5'd1), "R3 no forward of r0");
    send(i_st(5'd0, 5'd0), i_rr(5'd0, 5'd2, 5'd3), "R3 no sched flag on r0");
    send(NOP, NOP, "R3 drain");

    // R7: same-packet conflicts flagged, no stall
    send(i_st(5'd13, 5'd1), i_rr(5'd13, 5'd1, 5'd2), "R7 store data reads alu dest");
    send(i_ld(5'd14, 5'd13), i_imm(5'd13, 5'd2), "R7 base reads alu dest");
    send(i_ld(5'd15, 5'd3), i_imm(5'd15, 5'd3), "R7 both slots write r15");
    send(NOP, NOP, "R9 spacer");
    send(NOP, i_rr(5'd16, 5'd15, 5'd15), "R9 load wins in wb");
    send(NOP, NOP, "R9 drain");

    // R8: one stage ahead beats two stages ahead
    send(NOP, i_imm(5'd17, 5'd1), "R8 first writer r17");
    send(NOP, i_imm(5'd17, 5'd2), "R8 second writer r17");
    send(i_st(5'd17, 5'd17), i_rr(5'd18, 5'd17, 5'd0), "R8 em over wb");
    send(NOP, NOP, "R8 drain");

    // R2: branch, store and unknown opcode write nothing; unknown reads nothing
    send(i_st(5'd19, 5'd1), i_br(5'd19, 5'd1), "R2 branch and store");
    send(NOP, i_rr(5'd20, 5'd19, 5'd19), "R2 no writer for r19");
    send(i_ld(5'd21, 5'd1), NOP, "R2 load r21");
    send(i_unk(5'd21, 5'd21), i_unk(5'd21, 5'd21), "R2 unknown opcode reads nothing");
    send(i_ld(5'd22, 5'd1), NOP, "R4 load r22");
    send(NOP, NOP, "R4 nop packet after load");
    send(NOP, i_rr(5'd23, 5'd22, 5'd22), "R4 use two packets later no stall");
    repeat (4) send(NOP, NOP, "R1 drain");

    @(negedge clk);
    #2ns;
    finish_sim();
  end

endmodule